// File: doc/BRIEF.md
# Data Memory Address Generator

This block turns the operand of a file-register instruction of a small 8-bit controller core into a 12-bit data-memory address. Each access takes one of three paths. With the access-select bit clear, the 8-bit file field goes through a fixed split mapping called the access bank. With the bit set, the field is joined to a 4-bit bank register. When the result of either path names one of the virtual indirect registers, the address comes from a pointer register instead.

The block holds one 12-bit pointer register for each virtual indirect register. A literal can be loaded into any one of them. The address path is purely combinational, so the address, the indirect flag and the qualified write enable are valid in the same cycle as the operand. A pointer load takes effect at the next clock edge.

An indirect access whose pointer itself points at a virtual indirect register is made harmless. The block signals that the read returns zero, and it drops the write.

Top module: `dmag_top`

## Requirements
- R1: With `acc_sel`=1, and when the result is not a virtual indirect location, `mem_addr` = {`bank_sel`, `file_field`}.
- R2: With `acc_sel`=0 and `file_field` < 0x60, `mem_addr` = 0x000 + `file_field`, whatever the value of `bank_sel`.
- R3: With `acc_sel`=0 and `file_field` >= 0x60, `mem_addr` = 0xF00 + `file_field`, except at a virtual indirect location.
- R4: The virtual indirect locations are the resolved direct addresses 0xFEC, 0xFED and 0xFEE, for pointers 0, 1 and 2. Naming one, through the access bank or through bank 0xF, drives that pointer's value on `mem_addr` and sets `indirect`.
- R5: When `ptr_load` is high at a clock edge, pointer `ptr_idx` takes the value `ptr_value`. The other pointers keep their values. An index of 3 changes no pointer.
- R6: After reset all pointers are 0x000.
- R7: `indirect` is 0 for every access that does not name a virtual indirect location.
- R8: An indirect access whose pointer value is in 0xFEC..0xFEE sets `rd_zero` and forces `wr_en` to 0.
- R9: In all other cases `wr_en` equals `wr_req` and `rd_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| file_field | input | 8 | File address field of the instruction |
| acc_sel | input | 1 | 0 selects the access bank, 1 selects the bank register |
| bank_sel | input | 4 | Bank register value |
| wr_req | input | 1 | The instruction writes its destination |
| ptr_load | input | 1 | Load a literal into a pointer |
| ptr_idx | input | 2 | Pointer to load |
| ptr_value | input | 12 | Literal address to load |
| mem_addr | output | 12 | Resolved data-memory address |
| indirect | output | 1 | A pointer supplied the address |
| wr_en | output | 1 | Qualified write enable |
| rd_zero | output | 1 | Read data must be forced to zero |

## Verification
The bench uses the default parameters: 12-bit addresses, 8-bit file fields, three pointers, the split at 0x60 and the indirect block at 0xFEC. These values are small enough to sweep every file field against every bank value and both access-select values. The sweep covers all three paths, both edges of the 0x60 split, and each indirect location, reached through the access bank and through bank 0xF. The sweep is run twice: once with ordinary pointer values, and again with one pointer aimed at an indirect location, so that the read-zero and write-drop case is reached.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    typedef enum logic [1:0] {
        PATH_LOW  = 2'd0,
        PATH_HIGH = 2'd1,
        PATH_BANK = 2'd2
    } path_e;
endpackage

// File: rtl/dmag_direct.sv
module dmag_direct
    import dmag_pkg::*;
#(
    parameter int FW = 8,
    parameter int BW = 4,
    parameter logic [FW-1:0] SPLIT = 8'h60
) (
    input  logic [FW-1:0]    file_field,
    input  logic             acc_sel,
    input  logic [BW-1:0]    bank_sel,
    output logic [FW+BW-1:0] dir_addr,
    output path_e            path
);
    localparam int AW = FW + BW;

    always_comb begin
        if (acc_sel) begin
            path     = PATH_BANK;
            dir_addr = {bank_sel, file_field};
        end else if (file_field < SPLIT) begin
            path     = PATH_LOW;
            dir_addr = {{BW{1'b0}}, file_field};
        end else begin
            path     = PATH_HIGH;
            dir_addr = {{BW{1'b1}}, file_field};
        end
    end

    // R2: the low access-bank half always lands in the bottom page
    always_comb begin
        if (!acc_sel && file_field < SPLIT)
            assert_low_page_R2: assert (dir_addr[AW-1:FW] == '0);
    end
endmodule

// File: rtl/dmag_ptr_file.sv
module dmag_ptr_file #(
    parameter int AW   = 12,
    parameter int NPTR = 3,
    parameter int SW   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic [SW-1:0]         sel,
    input  logic [AW-1:0]         lit,
    output logic [NPTR*AW-1:0]    ptr_flat
);
    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPTR; i++) begin
            if (ld && sel == SW'(i))
                st_d.ptr[i] = lit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_flat = st_q.ptr;

    for (genvar g = 0; g < NPTR; g++) begin : g_chk
        assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ld && sel == SW'(g)) |=> st_q.ptr[g] == $past(lit));
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(ld && sel == SW'(g)) |=> $stable(st_q.ptr[g]));
    end
endmodule

// File: rtl/dmag_top.sv
module dmag_top
    import dmag_pkg::*;
#(
    parameter int FW   = 8,
    parameter int BW   = 4,
    parameter int NPTR = 3,
    parameter logic [FW-1:0] SPLIT = 8'h60,
    parameter logic [FW+BW-1:0] IND_BASE = 12'hFEC,
    parameter int AW = FW + BW,
    parameter int SW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] file_field,
    input  logic          acc_sel,
    input  logic [BW-1:0] bank_sel,
    input  logic          wr_req,
    input  logic          ptr_load,
    input  logic [SW-1:0] ptr_idx,
    input  logic [AW-1:0] ptr_value,
    output logic [AW-1:0] mem_addr,
    output logic          indirect,
    output logic          wr_en,
    output logic          rd_zero
);
    localparam logic [AW:0] IND_END = {1'b0, IND_BASE} + (AW+1)'(NPTR);

    logic [AW-1:0]        dir_addr;
    path_e                path;
    logic [NPTR*AW-1:0]   ptr_flat;
    logic [AW-1:0]        diff;
    logic                 hit;
    logic [AW-1:0]        sel_ptr;
    logic                 nested;

    dmag_direct #(.FW(FW), .BW(BW), .SPLIT(SPLIT)) u_dir (
        .file_field (file_field),
        .acc_sel    (acc_sel),
        .bank_sel   (bank_sel),
        .dir_addr   (dir_addr),
        .path       (path)
    );

    dmag_ptr_file #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ptr_load),
        .sel      (ptr_idx),
        .lit      (ptr_value),
        .ptr_flat (ptr_flat)
    );

    always_comb begin
        diff    = dir_addr - IND_BASE;
        hit     = (dir_addr >= IND_BASE) && ({1'b0, dir_addr} < IND_END);
        sel_ptr = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (hit && diff == AW'(i))
                sel_ptr = ptr_flat[i*AW +: AW];
        end
        nested   = hit && (sel_ptr >= IND_BASE) && ({1'b0, sel_ptr} < IND_END);
        mem_addr = hit ? sel_ptr : dir_addr;
        indirect = hit;
        rd_zero  = nested;
        wr_en    = wr_req && !nested;
    end

    assert_bank_concat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !indirect) |-> mem_addr == {bank_sel, file_field});
    assert_high_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel && file_field >= SPLIT && !indirect) |-> mem_addr[AW-1:FW] == {BW{1'b1}});
    assert_low_not_ind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel && file_field < SPLIT) |-> !indirect);
    assert_no_nested_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> (!wr_en && indirect));
    assert_write_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_zero |-> wr_en == wr_req);
endmodule

// File: tb/sim_dmag_top.sv
module sim_dmag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  file_field = '0;
    logic        acc_sel = 1'b0;
    logic [3:0]  bank_sel = '0;
    logic        wr_req = 1'b0;
    logic        ptr_load = 1'b0;
    logic [1:0]  ptr_idx = '0;
    logic [11:0] ptr_value = '0;
    logic [11:0] mem_addr;
    logic        indirect, wr_en, rd_zero;

    int checks = 0;
    int errors = 0;
    logic [11:0] model_ptr [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmag_top u0 (
        .clk(clk), .rst_n(rst_n), .file_field(file_field), .acc_sel(acc_sel),
        .bank_sel(bank_sel), .wr_req(wr_req), .ptr_load(ptr_load),
        .ptr_idx(ptr_idx), .ptr_value(ptr_value), .mem_addr(mem_addr),
        .indirect(indirect), .wr_en(wr_en), .rd_zero(rd_zero)
    );

    function automatic logic [11:0] direct_of(logic [7:0] f, logic a, logic [3:0] b);
        if (a) return {b, f};
        if (f < 8'h60) return {4'h0, f};
        return {4'hF, f};
    endfunction

    function automatic logic in_ind(logic [11:0] x);
        return x >= 12'hFEC && x <= 12'hFEE;
    endfunction

    task automatic check(string req, logic [14:0] act, logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s f=%h acc=%b bank=%h: got addr=%h ind=%b wr=%b rz=%b exp addr=%h ind=%b wr=%b rz=%b",
                     req, file_field, acc_sel, bank_sel, act[14:3], act[2], act[1], act[0],
                     exp[14:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic load(logic [1:0] idx, logic [11:0] v);
        @(negedge clk);
        ptr_load = 1'b1; ptr_idx = idx; ptr_value = v;
        @(negedge clk);
        ptr_load = 1'b0;
        if (idx < 2'd3) model_ptr[idx] = v;
    endtask

    task automatic sweep();
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 2; a++)
                for (int f = 0; f < 256; f++) begin
                    logic [11:0] d, ea;
                    logic ei, ez, ew;
                    string req;
                    @(negedge clk);
                    file_field = 8'(f); acc_sel = a[0]; bank_sel = 4'(b); wr_req = f[0];
                    #1;
                    d  = direct_of(8'(f), a[0], 4'(b));
                    ei = in_ind(d);
                    ea = ei ? model_ptr[d - 12'hFEC] : d;
                    ez = ei && in_ind(ea);
                    ew = f[0] && !ez;
                    if (ez)            req = "R8";
                    else if (ei)       req = "R4";
                    else if (a != 0)   req = "R1";
                    else if (f < 'h60) req = "R2";
                    else               req = "R3";
                    check(req, {mem_addr, indirect, wr_en, rd_zero}, {ea, ei, ew, ez});
                    if (!ei) check("R7", {12'h0, indirect, 2'b0}, 15'h0);
                    if (!ez) check("R9", {13'h0, wr_en, rd_zero}, {13'h0, ew, 1'b0});
                end
    endtask

    task automatic probe_ptr(int n, logic [11:0] exp, string req);
        @(negedge clk);
        acc_sel = 1'b0; file_field = 8'hEC + 8'(n); wr_req = 1'b0;
        #1;
        check(req, {mem_addr, indirect, 2'b0}, {exp, 1'b1, 2'b0});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) model_ptr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: all pointers read back as zero after reset
        for (int i = 0; i < 3; i++) probe_ptr(i, 12'h000, "R6");
        // R5: load each pointer, confirm the others held
        load(2'd0, 12'h123);
        probe_ptr(0, 12'h123, "R5");
        probe_ptr(1, 12'h000, "R5");
        load(2'd1, 12'h456);
        load(2'd2, 12'hABC);
        for (int i = 0; i < 3; i++) probe_ptr(i, model_ptr[i], "R5");
        // R5: index 3 loads nothing
        load(2'd3, 12'h777);
        for (int i = 0; i < 3; i++) probe_ptr(i, model_ptr[i], "R5");
        sweep();
        // R8: aim pointer 1 at an indirect location
        load(2'd1, 12'hFED);
        load(2'd2, 12'hFEF);
        sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule